// File: doc/BRIEF.md
# Sum-of-Products Macrocell Array with Borrowed Expander Terms

This block is an array of configurable sum-of-products cells. Every cell forms two product terms from a shared input bus, where each term ANDs any chosen inputs in true or complemented form. A cell ORs its own two terms together. It can also OR in term pairs that the cells further down the chain lend to it. The OR result either leaves the cell directly or passes through a per-cell flip-flop. Each flip-flop has a selectable clock and clock-enable pair and a selectable asynchronous clear.

All configuration is static: wide vectors that are held steady while the array runs. Cell `i` may borrow up to `MAX_SETS` lending sets, one set per neighbour, from cells `i+1 .. i+k`. `MAX_SETS` is the smaller of 15 and `N_MC-1`. With sixteen cells, one OR gate can therefore combine 32 terms. A cell whose pair is lent loses those terms from its own OR. A single error output flags any configuration that cannot be realised.

Top module: `ptm_macrocell_array`

## Requirements
- R1: A product term is the AND of all inputs whose include bit is 1. Each of those inputs is complemented when its invert bit is 1. A term with no include bit set evaluates to 0. Term t (0 or 1) of cell m uses bits `[(2m+t)*N_IN +: N_IN]` of `cfg_inc` and `cfg_inv`.
- R2: When `cfg_local_en[m]` is 1 and cell m is not lent, the cell's OR includes both of its own terms. When `cfg_local_en[m]` is 0, neither of its terms enters its own OR.
- R3: A value k in field `cfg_exp_sets[m*SW +: SW]` makes cell m OR in both terms of each of cells m+1 through m+k. k = 0 borrows nothing.
- R4: A cell whose pair is lent to another cell never drives its own OR with those terms, even when `cfg_local_en` is 1.
- R5: `cfg_err` is 1 exactly when at least one of these holds: a lent cell has `cfg_local_en` set; a cell is lent to two receivers; or a requested k exceeds `MAX_SETS` or runs past the last cell.
- R6: With `cfg_bypass[m]` = 1, `mc_out[m]` follows the OR result combinationally. With `cfg_bypass[m]` = 0, `mc_out[m]` shows the flip-flop.
- R7: `cfg_clk_sel[m]` picks clock pair 0 or 1. The flip-flop loads the OR result on a rising edge of `clk_in[sel]` only while `clk_ena[sel]` is 1, and otherwise holds.
- R8: The effective clear c is `clr_in[c] ^ cfg_clr_inv[c]`. The 2-bit field `cfg_clr_sel[2m +: 2]` selects as follows: 0 means no clear, 1 means clear 0, 2 means clear 1, and 3 means no clear.
- R9: The selected active clear forces the flip-flop to 0 at once. It wins over any clock edge while it stays active.
- R10: While `rst_n` is low, every flip-flop is cleared asynchronously. The release is synchronised by two stages to each cell's selected clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 2 | The two clock inputs |
| clk_ena | input | 2 | Clock enable paired with each clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | N_IN | Shared product-term input bus |
| clr_in | input | 2 | Raw asynchronous clear sources |
| cfg_inc | input | 2*N_MC*N_IN | Per-term include masks |
| cfg_inv | input | 2*N_MC*N_IN | Per-term invert masks |
| cfg_local_en | input | N_MC | Cell uses its own terms |
| cfg_exp_sets | input | N_MC*SW | Number of borrowed sets per cell |
| cfg_bypass | input | N_MC | Route OR result around the flip-flop |
| cfg_clk_sel | input | N_MC | Clock pair select per cell |
| cfg_clr_inv | input | 2 | Invert each clear source |
| cfg_clr_sel | input | 2*N_MC | Clear select per cell |
| mc_out | output | N_MC | Cell outputs |
| cfg_err | output | 1 | Illegal configuration flag |

## Verification
The hardest situation to reach from the ports is a lent cell that still has its local enable set. In that case the cell's own output must stay at 0 while its terms are true, and the receiver must still see them. The stimulus first sets up a legal two-set borrow. It then sets the lender's local enable and drives the lender's term input high with the lender in bypass. This shows the dropped terms and the error flag together. Double lending is then produced by making a second cell reach the same lender, and an over-long borrow is produced on the last cell.

// File: rtl/ptm_pkg.sv
package ptm_pkg;
  typedef enum logic [1:0] {
    CLR_NONE = 2'd0,
    CLR_SRC0 = 2'd1,
    CLR_SRC1 = 2'd2,
    CLR_OFF  = 2'd3
  } clr_sel_e;

  localparam int unsigned HW_SET_LIMIT = 15;
endpackage

// File: rtl/ptm_and_plane.sv
module ptm_and_plane #(
  parameter int N_IN   = 8,
  parameter int N_TERM = 8
) (
  input  logic [N_IN-1:0]        din_i,
  input  logic [N_TERM*N_IN-1:0] inc_i,
  input  logic [N_TERM*N_IN-1:0] inv_i,
  output logic [N_TERM-1:0]      term_o
);
  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [N_IN-1:0] lit;
    logic [N_IN-1:0] msk;
    assign msk = inc_i[t*N_IN +: N_IN];
    assign lit = (din_i ^ inv_i[t*N_IN +: N_IN]) | ~msk;
    assign term_o[t] = (|msk) & (&lit);
  end
endmodule

// File: rtl/ptm_expander_steer.sv
module ptm_expander_steer #(
  parameter int N_MC     = 4,
  parameter int MAX_SETS = 3,
  parameter int SW       = 2
) (
  input  logic [2*N_MC-1:0]  term_i,
  input  logic [N_MC-1:0]    local_en_i,
  input  logic [N_MC*SW-1:0] sets_i,
  output logic [N_MC-1:0]    or_o,
  output logic [N_MC-1:0]    lent_o,
  output logic               err_o
);
  logic [N_MC-1:0] lent_c;
  logic [N_MC-1:0] borrow_c;
  logic            multi_c;
  logic            over_c;

  always_comb begin
    int k;
    int j;
    lent_c   = '0;
    borrow_c = '0;
    multi_c  = 1'b0;
    over_c   = 1'b0;
    for (int i = 0; i < N_MC; i++) begin
      k = int'(sets_i[i*SW +: SW]);
      if (k > MAX_SETS || i + k > N_MC - 1) over_c = 1'b1;
      for (int s = 1; s <= MAX_SETS; s++) begin
        j = (i + s < N_MC) ? i + s : 0;
        if (s <= k && i + s < N_MC) begin
          if (lent_c[j]) multi_c = 1'b1;
          lent_c[j]   = 1'b1;
          borrow_c[i] = borrow_c[i] | term_i[2*j] | term_i[2*j+1];
        end
      end
    end
  end

  for (genvar m = 0; m < N_MC; m++) begin : g_or
    assign or_o[m] = borrow_c[m] |
                     (local_en_i[m] & ~lent_c[m] & (term_i[2*m] | term_i[2*m+1]));
  end

  assign lent_o = lent_c;
  assign err_o  = over_c | multi_c | (|(lent_c & local_en_i));
endmodule

// File: rtl/ptm_mc_reg.sv
module ptm_mc_reg (
  input  logic clk_i,
  input  logic rsn_i,
  input  logic ena_i,
  input  logic clr_i,
  input  logic d_i,
  input  logic bypass_i,
  output logic out_o
);
  logic aclr;
  logic q_r;
  logic q_nxt;

  assign aclr = ~rsn_i | clr_i;

  always_comb begin
    q_nxt = q_r;
    if (ena_i) q_nxt = d_i;
  end

  always_ff @(posedge clk_i or posedge aclr) begin
    if (aclr) q_r <= 1'b0;
    else      q_r <= q_nxt;
  end

  assign out_o = bypass_i ? d_i : q_r;

  AST_CLR_FORCES_ZERO: assert property (@(posedge clk_i) disable iff (!rsn_i)
    clr_i |-> (q_r == 1'b0)); // R9
  AST_ENA_HOLD: assert property (@(posedge clk_i) disable iff (aclr)
    !ena_i |=> (q_r == $past(q_r))); // R7
  AST_RESET_CLEARS: assert property (@(posedge clk_i) disable iff (rsn_i)
    1'b1 |-> (q_r == 1'b0)); // R10
endmodule

// File: rtl/ptm_macrocell_array.sv
module ptm_macrocell_array
  import ptm_pkg::*;
#(
  parameter int N_IN = 8,
  parameter int N_MC = 4,
  localparam int MAX_SETS = (N_MC - 1 > HW_SET_LIMIT) ? HW_SET_LIMIT : N_MC - 1,
  localparam int SW = (MAX_SETS < 2) ? 1 : $clog2(MAX_SETS + 1),
  localparam int N_TERM = 2 * N_MC
) (
  input  logic [1:0]             clk_in,
  input  logic [1:0]             clk_ena,
  input  logic                   rst_n,
  input  logic [N_IN-1:0]        din,
  input  logic [1:0]             clr_in,
  input  logic [N_TERM*N_IN-1:0] cfg_inc,
  input  logic [N_TERM*N_IN-1:0] cfg_inv,
  input  logic [N_MC-1:0]        cfg_local_en,
  input  logic [N_MC*SW-1:0]     cfg_exp_sets,
  input  logic [N_MC-1:0]        cfg_bypass,
  input  logic [N_MC-1:0]        cfg_clk_sel,
  input  logic [1:0]             cfg_clr_inv,
  input  logic [2*N_MC-1:0]      cfg_clr_sel,
  output logic [N_MC-1:0]        mc_out,
  output logic                   cfg_err
);
  logic [N_TERM-1:0] term;
  logic [N_MC-1:0]   or_sum;
  logic [N_MC-1:0]   lent;
  logic [1:0]        rst_sync_n;
  logic [1:0]        eff_clr;

  assign eff_clr = clr_in ^ cfg_clr_inv;

  for (genvar c = 0; c < 2; c++) begin : g_rsync
    logic s1_r;
    logic s2_r;
    always_ff @(posedge clk_in[c] or negedge rst_n) begin
      if (!rst_n) begin
        s1_r <= 1'b0;
        s2_r <= 1'b0;
      end else begin
        s1_r <= 1'b1;
        s2_r <= s1_r;
      end
    end
    assign rst_sync_n[c] = s2_r;
  end

  ptm_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_plane (
    .din_i (din),
    .inc_i (cfg_inc),
    .inv_i (cfg_inv),
    .term_o(term)
  );

  ptm_expander_steer #(.N_MC(N_MC), .MAX_SETS(MAX_SETS), .SW(SW)) u_steer (
    .term_i    (term),
    .local_en_i(cfg_local_en),
    .sets_i    (cfg_exp_sets),
    .or_o      (or_sum),
    .lent_o    (lent),
    .err_o     (cfg_err)
  );

  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    logic     mc_clk;
    logic     mc_ena;
    logic     mc_rsn;
    logic     mc_clr;
    clr_sel_e sel;

    assign sel    = clr_sel_e'(cfg_clr_sel[2*m +: 2]);
    assign mc_clk = cfg_clk_sel[m] ? clk_in[1] : clk_in[0];
    assign mc_ena = cfg_clk_sel[m] ? clk_ena[1] : clk_ena[0];
    assign mc_rsn = cfg_clk_sel[m] ? rst_sync_n[1] : rst_sync_n[0];

    always_comb begin
      case (sel)
        CLR_SRC0: mc_clr = eff_clr[0];
        CLR_SRC1: mc_clr = eff_clr[1];
        default:  mc_clr = 1'b0;
      endcase
    end

    ptm_mc_reg u_reg (
      .clk_i   (mc_clk),
      .rsn_i   (mc_rsn),
      .ena_i   (mc_ena),
      .clr_i   (mc_clr),
      .d_i     (or_sum[m]),
      .bypass_i(cfg_bypass[m]),
      .out_o   (mc_out[m])
    );

    AST_CONFLICT_FLAG: assert property (@(posedge clk_in[0]) disable iff (!rst_n)
      (lent[m] && cfg_local_en[m]) |-> cfg_err); // R5
    AST_IDLE_CELL_LOW: assert property (@(posedge clk_in[0]) disable iff (!rst_n)
      (!cfg_local_en[m] && cfg_exp_sets[m*SW +: SW] == '0 && cfg_bypass[m])
        |-> (mc_out[m] == 1'b0)); // R2
    AST_EMPTY_TERM_A: assert property (@(posedge clk_in[0]) disable iff (!rst_n)
      (cfg_inc[(2*m)*N_IN +: N_IN] == '0) |-> (term[2*m] == 1'b0)); // R1
    AST_EMPTY_TERM_B: assert property (@(posedge clk_in[0]) disable iff (!rst_n)
      (cfg_inc[(2*m+1)*N_IN +: N_IN] == '0) |-> (term[2*m+1] == 1'b0)); // R1
  end
endmodule

// File: tb/ptm_macrocell_array_bench.sv
module ptm_macrocell_array_bench;
  localparam int N_IN = 8;
  localparam int N_MC = 4;
  localparam int SW   = 2;

  logic [1:0]          clk_in;
  logic [1:0]          clk_ena;
  logic                rst_n;
  logic [N_IN-1:0]     din;
  logic [1:0]          clr_in;
  logic [2*N_MC*N_IN-1:0] cfg_inc;
  logic [2*N_MC*N_IN-1:0] cfg_inv;
  logic [N_MC-1:0]     cfg_local_en;
  logic [N_MC*SW-1:0]  cfg_exp_sets;
  logic [N_MC-1:0]     cfg_bypass;
  logic [N_MC-1:0]     cfg_clk_sel;
  logic [1:0]          cfg_clr_inv;
  logic [2*N_MC-1:0]   cfg_clr_sel;
  logic [N_MC-1:0]     mc_out;
  logic                cfg_err;

  int n_chk;
  int n_bad;

  ptm_macrocell_array #(.N_IN(N_IN), .N_MC(N_MC)) u_ptm_macrocell_array (
    .clk_in(clk_in), .clk_ena(clk_ena), .rst_n(rst_n), .din(din), .clr_in(clr_in),
    .cfg_inc(cfg_inc), .cfg_inv(cfg_inv), .cfg_local_en(cfg_local_en),
    .cfg_exp_sets(cfg_exp_sets), .cfg_bypass(cfg_bypass), .cfg_clk_sel(cfg_clk_sel),
    .cfg_clr_inv(cfg_clr_inv), .cfg_clr_sel(cfg_clr_sel), .mc_out(mc_out), .cfg_err(cfg_err)
  );

  initial begin
    clk_in[0] = 1'b0;
    forever #2 clk_in[0] = ~clk_in[0];
  end
  initial begin
    clk_in[1] = 1'b0;
    forever #6 clk_in[1] = ~clk_in[1];
  end

  task automatic check(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic set_term(input int m, input int t, input logic [N_IN-1:0] inc,
                          input logic [N_IN-1:0] inv);
    cfg_inc[(2*m+t)*N_IN +: N_IN] = inc;
    cfg_inv[(2*m+t)*N_IN +: N_IN] = inv;
  endtask

  task automatic clear_cfg();
    clk_ena = 2'b00;
    clr_in = 2'b00;
    cfg_inc = '0; cfg_inv = '0; cfg_local_en = '0; cfg_exp_sets = '0;
    cfg_bypass = '0; cfg_clk_sel = '0; cfg_clr_inv = 2'b00; cfg_clr_sel = '0;
    din = '0;
  endtask

  task automatic t_reset();
    clear_cfg();
    rst_n = 1'b0;
    repeat (3) @(negedge clk_in[0]);
    check("R10 out low in reset", mc_out[0], 1'b0);
    rst_n = 1'b1;
    repeat (16) @(negedge clk_in[0]);
    check("R10 out low after release", mc_out[0], 1'b0);
    check("R5 err clear on empty cfg", cfg_err, 1'b0);
  endtask

  task automatic t_terms();
    clear_cfg();
    cfg_local_en[0] = 1'b1;
    cfg_bypass[0] = 1'b1;
    set_term(0, 0, 8'h03, 8'h02);
    din = 8'h01; #1 check("R1 in0&~in1 true", mc_out[0], 1'b1);
    din = 8'h03; #1 check("R1 in1 complemented", mc_out[0], 1'b0);
    din = 8'h00; #1 check("R1 in0 low", mc_out[0], 1'b0);
    din = 8'h81; #1 check("R1 unselected bit ignored", mc_out[0], 1'b1);
    set_term(0, 1, 8'hF0, 8'h00);
    din = 8'hF0; #1 check("R2 second own term", mc_out[0], 1'b1);
    cfg_local_en[0] = 1'b0;
    #1 check("R2 local disable", mc_out[0], 1'b0);
    cfg_local_en[0] = 1'b1;
    set_term(0, 0, 8'h00, 8'hFF);
    set_term(0, 1, 8'h00, 8'h00);
    din = 8'hFF; #1 check("R1 empty term zero", mc_out[0], 1'b0);
    din = 8'h00; #1 check("R1 empty term zero inv", mc_out[0], 1'b0);
  endtask

  task automatic setup_borrow();
    clear_cfg();
    cfg_local_en[0] = 1'b1;
    set_term(0, 0, 8'h01, 8'h00);
    set_term(1, 0, 8'h04, 8'h00);
    set_term(2, 1, 8'h08, 8'h00);
    set_term(3, 0, 8'h10, 8'h00);
    cfg_exp_sets[0 +: SW] = 2'd2;
    cfg_bypass[1:0] = 2'b11;
  endtask

  task automatic t_expand();
    setup_borrow();
    din = 8'h04; #1 check("R3 term of cell1 reaches cell0", mc_out[0], 1'b1);
    check("R4 lent cell1 output low", mc_out[1], 1'b0);
    din = 8'h08; #1 check("R3 term of cell2 reaches cell0", mc_out[0], 1'b1);
    din = 8'h01; #1 check("R2 own term with borrow", mc_out[0], 1'b1);
    din = 8'h10; #1 check("R3 cell3 outside window", mc_out[0], 1'b0);
    check("R5 legal borrow no err", cfg_err, 1'b0);
    cfg_exp_sets[0 +: SW] = 2'd1;
    din = 8'h08; #1 check("R3 k=1 excludes cell2", mc_out[0], 1'b0);
    din = 8'h04; #1 check("R3 k=1 includes cell1", mc_out[0], 1'b1);
  endtask

  task automatic t_conflict();
    setup_borrow();
    cfg_local_en[1] = 1'b1;
    din = 8'h04; #1 check("R4 lent cell with local_en stays low", mc_out[1], 1'b0);
    check("R5 lent cell local_en flags", cfg_err, 1'b1);
    check("R4 receiver still sees term", mc_out[0], 1'b1);
    cfg_local_en[1] = 1'b0;
    #1 check("R5 cleared", cfg_err, 1'b0);
    cfg_exp_sets[3*SW +: SW] = 2'd1;
    #1 check("R5 borrow past end", cfg_err, 1'b1);
    cfg_exp_sets[3*SW +: SW] = 2'd0;
    cfg_exp_sets[1*SW +: SW] = 2'd1;
    #1 check("R5 cell lent twice", cfg_err, 1'b1);
    cfg_exp_sets[1*SW +: SW] = 2'd0;
    #1 check("R5 back to legal", cfg_err, 1'b0);
  endtask

  task automatic t_register();
    clear_cfg();
    @(negedge clk_in[0]);
    cfg_local_en[0] = 1'b1;
    set_term(0, 0, 8'h01, 8'h00);
    din = 8'h01;
    @(negedge clk_in[0]);
    check("R7 disabled holds", mc_out[0], 1'b0);
    clk_ena[0] = 1'b1;
    @(negedge clk_in[0]);
    check("R7 enabled loads", mc_out[0], 1'b1);
    din = 8'h00; #1
    check("R6 registered before edge", mc_out[0], 1'b1);
    @(negedge clk_in[0]);
    check("R7 loads zero", mc_out[0], 1'b0);
    clk_ena = 2'b00;
    cfg_local_en[1] = 1'b1;
    set_term(1, 0, 8'h20, 8'h00);
    cfg_clk_sel[1] = 1'b1;
    @(posedge clk_in[1]);
    #1 clk_ena[1] = 1'b1; din = 8'h20;
    @(negedge clk_in[0]);
    @(negedge clk_in[0]);
    check("R7 clock 1 not yet", mc_out[1], 1'b0);
    @(posedge clk_in[1]);
    #1 check("R7 clock 1 edge loads", mc_out[1], 1'b1);
    clk_ena = 2'b00;
  endtask

  task automatic t_clear();
    clear_cfg();
    @(negedge clk_in[0]);
    cfg_local_en[0] = 1'b1;
    set_term(0, 0, 8'h01, 8'h00);
    din = 8'h01;
    clk_ena[0] = 1'b1;
    cfg_clr_sel[1:0] = 2'd1;
    @(negedge clk_in[0]);
    check("R7 preload", mc_out[0], 1'b1);
    clr_in[0] = 1'b1; #1
    check("R9 async clear immediate", mc_out[0], 1'b0);
    repeat (2) @(negedge clk_in[0]);
    check("R9 clear beats edges", mc_out[0], 1'b0);
    clr_in[0] = 1'b0;
    @(negedge clk_in[0]);
    check("R9 reload after clear", mc_out[0], 1'b1);
    clr_in[1] = 1'b1;
    @(negedge clk_in[0]);
    check("R8 sel=1 ignores clear1", mc_out[0], 1'b1);
    cfg_clr_sel[1:0] = 2'd2; #1
    check("R8 sel=2 uses clear1", mc_out[0], 1'b0);
    cfg_clr_sel[1:0] = 2'd3;
    @(negedge clk_in[0]);
    check("R8 sel=3 no clear", mc_out[0], 1'b1);
    clr_in = 2'b00;
    cfg_clr_inv[0] = 1'b1;
    cfg_clr_sel[1:0] = 2'd1; #1
    check("R8 inverted clear0 active low", mc_out[0], 1'b0);
    cfg_clr_sel[1:0] = 2'd0;
    @(negedge clk_in[0]);
    check("R8 sel=0 no clear", mc_out[0], 1'b1);
    clk_ena = 2'b00;
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    t_reset();
    t_terms();
    t_expand();
    t_conflict();
    t_register();
    t_clear();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule